// File: doc/BRIEF.md
# Operand Forwarding and Stall Unit

This block decides, for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback), when an instruction must wait for a result it reads and where each ALU operand of the instruction in execute should be taken from. It compares the two source register numbers of the instruction in decode against the destinations held in the decode/execute and execute/memory pipeline registers. It also compares the two source register numbers of the instruction in execute against the destinations in the execute/memory and memory/writeback registers. From these comparisons it produces one operand-select code per source, a hold for the program counter and the fetch/decode register, and a request to load an empty bubble into decode/execute.

The block has no state. The same comparisons are repeated every cycle, so a stall of two cycles arises because the hazard is still present on the second cycle. The register file writes in the first half of a cycle and reads in the second half, so a result three or more instructions back is always read from the register file. The parameter `FWD_MODE` chooses the available bypass paths at elaboration: 0 means no bypass, 1 means a two-input mux fed only from execute/memory, 2 means a two-input mux fed only from memory/writeback, and 3 means a three-input mux fed from both. Each mode has its own stall cost for a given dependence distance.

Top module: `fwd_stall_unit`

## Requirements
- R1: A producer that is three or more instructions older than its consumer never causes a stall or a bypass: the consumer reads the register file (select 2'b00) with no hold cycle.
- R2: With `FWD_MODE`=0, a consumer that reads the result of the instruction just before it is held 2 cycles. A consumer that reads only the result of the instruction two before it is held 1 cycle. A consumer that reads both is held 2 cycles. Both selects stay 2'b00.
- R3: With `FWD_MODE`=3, the only stall is 1 cycle, when the instruction just before is a load (`ex_load`=1) that writes a register the consumer reads. The select is 2'b01 when the value comes from execute/memory and 2'b10 when it comes from memory/writeback.
- R4: With `FWD_MODE`=3, when both execute/memory and memory/writeback write the source register of the instruction in execute, the select is 2'b01, the younger result.
- R5: With `FWD_MODE`=1, an ALU result needed by the next instruction is bypassed (2'b01) with no stall. A dependence whose youngest producer is two instructions back costs 1 stall cycle. A load needed by the next instruction costs 2 stall cycles. The select is never 2'b10.
- R6: With `FWD_MODE`=2, a dependence on the instruction just before costs 1 stall cycle and is then bypassed with select 2'b10. A dependence two back is bypassed with 2'b10 and no stall. The select is never 2'b01.
- R7: A producer whose write enable is low, or whose destination is register 0, and a source that names register 0, never cause a stall or a bypass.
- R8: `hold` and `bubble` are always equal and are high exactly in the cycles in which the decode instruction must wait. With all inputs zero (empty pipeline), all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded checks |
| rst_n | input | 1 | Active-low reset, used only by the embedded checks |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| ex_rs1 | input | REG_W | First source register of the execute instruction |
| ex_rs2 | input | REG_W | Second source register of the execute instruction |
| ex_rd | input | REG_W | Destination held in decode/execute |
| ex_we | input | 1 | Register write enable held in decode/execute |
| ex_load | input | 1 | Decode/execute instruction reads memory |
| mem_rd | input | REG_W | Destination held in execute/memory |
| mem_we | input | 1 | Register write enable held in execute/memory |
| wb_rd | input | REG_W | Destination held in memory/writeback |
| wb_we | input | 1 | Register write enable held in memory/writeback |
| fwd_a | output | 2 | First operand source: 00 register file, 01 execute/memory, 10 memory/writeback |
| fwd_b | output | 2 | Second operand source, same encoding |
| hold | output | 1 | Freeze program counter and fetch/decode register |
| bubble | output | 1 | Load an all-zero bubble into decode/execute |

## Verification
The block is purely combinational, so a wrong comparison shows at the ports in the same cycle it is presented. A missed or extra stall shifts the cycle in which every later instruction reaches execute. That changes the total number of held cycles for the sequence, and it also changes the distance, and so the select, that the consumer sees one or two cycles later. A bypass from the wrong stage, or from an older producer, shows as a wrong select code when the consumer is in execute. Because of this, the bench replays short instruction sequences through a pipeline model. For each sequence it compares the total hold count and the select seen by every instruction in execute.

// File: rtl/fwd_stall_unit.sv
module fwd_stall_unit #(
  parameter int REG_W    = 5,
  parameter int FWD_MODE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             hold,
  output logic             bubble
);
  localparam bit HAS_XM = (FWD_MODE == 1) || (FWD_MODE == 3);
  localparam bit HAS_MW = (FWD_MODE == 2) || (FWD_MODE == 3);
  localparam logic [1:0] SEL_RF = 2'b00;
  localparam logic [1:0] SEL_XM = 2'b01;
  localparam logic [1:0] SEL_MW = 2'b10;

  wire ex_live  = ex_we  && (ex_rd  != '0);
  wire mem_live = mem_we && (mem_rd != '0);
  wire wb_live  = wb_we  && (wb_rd  != '0);

  wire id1_ex  = ex_live  && (ex_rd  == id_rs1);
  wire id2_ex  = ex_live  && (ex_rd  == id_rs2);
  wire id1_mem = mem_live && (mem_rd == id_rs1);
  wire id2_mem = mem_live && (mem_rd == id_rs2);

  wire ex1_mem = mem_live && (mem_rd == ex_rs1);
  wire ex2_mem = mem_live && (mem_rd == ex_rs2);
  wire ex1_wb  = wb_live  && (wb_rd  == ex_rs1);
  wire ex2_wb  = wb_live  && (wb_rd  == ex_rs2);

  logic wait1, wait2;

  generate
    if (FWD_MODE == 0) begin : g_none
      assign wait1 = id1_ex || id1_mem;
      assign wait2 = id2_ex || id2_mem;
    end else if (FWD_MODE == 1) begin : g_xm
      assign wait1 = (id1_ex && ex_load) || (id1_mem && !id1_ex);
      assign wait2 = (id2_ex && ex_load) || (id2_mem && !id2_ex);
    end else if (FWD_MODE == 2) begin : g_mw
      assign wait1 = id1_ex;
      assign wait2 = id2_ex;
    end else begin : g_full
      assign wait1 = id1_ex && ex_load;
      assign wait2 = id2_ex && ex_load;
    end
  endgenerate

  function automatic logic [1:0] pick(input logic hit_xm, input logic hit_mw);
    if (HAS_XM && hit_xm)      return SEL_XM;
    else if (HAS_MW && hit_mw) return SEL_MW;
    else                       return SEL_RF;
  endfunction

  assign fwd_a  = pick(ex1_mem, ex1_wb);
  assign fwd_b  = pick(ex2_mem, ex2_wb);
  assign hold   = wait1 || wait2;
  assign bubble = wait1 || wait2;

  p_r0_src_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == '0 && ex_rs2 == '0) |-> (fwd_a == SEL_RF && fwd_b == SEL_RF));

  p_r0_id_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0 && id_rs2 == '0) |-> (!hold && !bubble));

  p_no_wb_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_we && !mem_we) |-> !hold);

  p_hold_is_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold == bubble);

  generate
    if (FWD_MODE == 3) begin : g_full_chk
      p_load_use_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_load && ex_we && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2)) |-> hold);
      p_alu_nostall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_load |-> !hold);
      p_young_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_rd != '0 && mem_rd == ex_rs1) |-> fwd_a == SEL_XM);
    end
    if (FWD_MODE == 1) begin : g_xm_chk
      p_no_mw_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != SEL_MW) && (fwd_b != SEL_MW));
    end
    if (FWD_MODE == 2) begin : g_mw_chk
      p_no_xm_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != SEL_XM) && (fwd_b != SEL_XM));
    end
    if (FWD_MODE == 0) begin : g_none_chk
      p_rf_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a == SEL_RF) && (fwd_b == SEL_RF));
    end
  endgenerate
endmodule

// File: tb/tb_fwd_stall_unit.sv
module tb_fwd_stall_unit;
  localparam int RW = 5;
  localparam int MAXN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
  logic [RW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic ex_we = 1'b0, ex_load = 1'b0, mem_we = 1'b0, wb_we = 1'b0;

  logic [1:0] fa_w [0:3];
  logic [1:0] fb_w [0:3];
  logic       hd_w [0:3];
  logic       bb_w [0:3];

  fwd_stall_unit #(.REG_W(RW), .FWD_MODE(3)) dut (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .fwd_a(fa_w[3]), .fwd_b(fb_w[3]), .hold(hd_w[3]), .bubble(bb_w[3]));
  fwd_stall_unit #(.REG_W(RW), .FWD_MODE(0)) dut_none (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .fwd_a(fa_w[0]), .fwd_b(fb_w[0]), .hold(hd_w[0]), .bubble(bb_w[0]));
  fwd_stall_unit #(.REG_W(RW), .FWD_MODE(1)) dut_xm (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .fwd_a(fa_w[1]), .fwd_b(fb_w[1]), .hold(hd_w[1]), .bubble(bb_w[1]));
  fwd_stall_unit #(.REG_W(RW), .FWD_MODE(2)) dut_mw (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we),
    .wb_rd(wb_rd), .wb_we(wb_we), .fwd_a(fa_w[2]), .fwd_b(fb_w[2]), .hold(hd_w[2]), .bubble(bb_w[2]));

  int errors = 0;
  int checks = 0;

  int n_ins;
  logic [RW-1:0] p_rd [MAXN];
  logic [RW-1:0] p_rs1 [MAXN];
  logic [RW-1:0] p_rs2 [MAXN];
  bit p_we [MAXN];
  bit p_ld [MAXN];

  int e_t [MAXN];
  logic [1:0] e_fa [MAXN];
  logic [1:0] e_fb [MAXN];
  logic [1:0] g_fa [MAXN];
  logic [1:0] g_fb [MAXN];
  bit agree_ok;

  int id_i, ex_i, mem_i, wb_i, pc;

  task automatic check(input bit ok, input string tag, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic string mode_tag(input int mode);
    case (mode)
      0: return "R2";
      1: return "R5";
      2: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic set_ins(input int i, input int rd, input int rs1, input int rs2, input bit we, input bit ld);
    p_rd[i] = RW'(rd); p_rs1[i] = RW'(rs1); p_rs2[i] = RW'(rs2); p_we[i] = we; p_ld[i] = ld;
  endtask

  function automatic int youngest(input int i, input logic [RW-1:0] s);
    for (int j = i - 1; j >= 0; j--)
      if (p_we[j] && p_rd[j] == s && s != '0) return j;
    return -1;
  endfunction

  function automatic bit need_stall(input int mode, input int i, input logic [RW-1:0] s, input int ti);
    int j;
    int g;
    j = youngest(i, s);
    if (j < 0) return 1'b0;
    g = ti - e_t[j];
    case (mode)
      0: return (g == 1) || (g == 2);
      1: return (g == 1 && p_ld[j]) || (g == 2);
      2: return g == 1;
      default: return g == 1 && p_ld[j];
    endcase
  endfunction

  function automatic logic [1:0] exp_sel(input int mode, input int i, input logic [RW-1:0] s, input int ti);
    int j;
    int g;
    j = youngest(i, s);
    if (j < 0) return 2'b00;
    g = ti - e_t[j];
    if (g == 1 && (mode == 1 || mode == 3)) return 2'b01;
    if (g == 2 && (mode == 2 || mode == 3)) return 2'b10;
    return 2'b00;
  endfunction

  task automatic compute_expected(input int mode, output int st);
    for (int i = 0; i < n_ins; i++) begin
      int guard;
      guard = 0;
      e_t[i] = (i == 0) ? 0 : e_t[i-1] + 1;
      while ((need_stall(mode, i, p_rs1[i], e_t[i]) || need_stall(mode, i, p_rs2[i], e_t[i])) && guard < 10) begin
        e_t[i]++;
        guard++;
      end
      e_fa[i] = exp_sel(mode, i, p_rs1[i], e_t[i]);
      e_fb[i] = exp_sel(mode, i, p_rs2[i], e_t[i]);
    end
    st = e_t[n_ins-1] - (n_ins - 1);
  endtask

  task automatic drive_stages();
    id_rs1  = (id_i >= 0) ? p_rs1[id_i] : '0;
    id_rs2  = (id_i >= 0) ? p_rs2[id_i] : '0;
    ex_rs1  = (ex_i >= 0) ? p_rs1[ex_i] : '0;
    ex_rs2  = (ex_i >= 0) ? p_rs2[ex_i] : '0;
    ex_rd   = (ex_i >= 0) ? p_rd[ex_i] : '0;
    ex_we   = (ex_i >= 0) ? p_we[ex_i] : 1'b0;
    ex_load = (ex_i >= 0) ? p_ld[ex_i] : 1'b0;
    mem_rd  = (mem_i >= 0) ? p_rd[mem_i] : '0;
    mem_we  = (mem_i >= 0) ? p_we[mem_i] : 1'b0;
    wb_rd   = (wb_i >= 0) ? p_rd[wb_i] : '0;
    wb_we   = (wb_i >= 0) ? p_we[wb_i] : 1'b0;
  endtask

  task automatic run_model(input int mode, output int st);
    int guard;
    bit h;
    st = 0; guard = 0; agree_ok = 1'b1;
    id_i = 0; ex_i = -1; mem_i = -1; wb_i = -1; pc = 1;
    for (int i = 0; i < MAXN; i++) begin g_fa[i] = 2'b11; g_fb[i] = 2'b11; end
    while ((id_i >= 0 || ex_i >= 0 || mem_i >= 0 || wb_i >= 0) && guard < 80) begin
      drive_stages();
      #1;
      h = hd_w[mode];
      if (hd_w[mode] != bb_w[mode]) agree_ok = 1'b0;
      if (id_i < 0 && h) agree_ok = 1'b0;
      if (ex_i >= 0) begin g_fa[ex_i] = fa_w[mode]; g_fb[ex_i] = fb_w[mode]; end
      if (h) st++;
      wb_i = mem_i;
      mem_i = ex_i;
      if (h) ex_i = -1;
      else begin
        ex_i = id_i;
        id_i = (pc < n_ins) ? pc : -1;
        pc++;
      end
      guard++;
      @(negedge clk);
    end
    id_i = -1; ex_i = -1; mem_i = -1; wb_i = -1;
    drive_stages();
  endtask

  task automatic run_case(input int mode, input int hard, output int got);
    int st_exp;
    string tag;
    tag = mode_tag(mode);
    compute_expected(mode, st_exp);
    run_model(mode, got);
    check(got == st_exp, tag, "total stall cycles", got, st_exp);
    if (hard >= 0) check(got == hard, tag, "stall cycles against fixed value", got, hard);
    for (int i = 0; i < n_ins; i++)
      check(g_fa[i] == e_fa[i] && g_fb[i] == e_fb[i], tag, $sformatf("selects {a,b} of instr %0d", i),
            {g_fa[i], g_fb[i]}, {e_fa[i], e_fb[i]});
    check(agree_ok, "R8", "hold equals bubble and only with a decode instruction", agree_ok, 1);
  endtask

  task automatic finish_report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_report();
  end

  localparam int D1 [4] = '{2, 0, 1, 0};
  localparam int D2 [4] = '{2, 2, 1, 1};
  localparam int D3 [4] = '{1, 1, 0, 0};
  localparam int D4 [4] = '{2, 2, 1, 0};

  initial begin
    int st;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    for (int m = 0; m < 4; m++)
      check(fa_w[m] == 0 && fb_w[m] == 0 && !hd_w[m] && !bb_w[m], "R8", $sformatf("idle outputs mode %0d", m),
            {fa_w[m], fb_w[m], hd_w[m], bb_w[m]}, 0);
    @(negedge clk);

    // dependence on the previous ALU result
    n_ins = 3;
    set_ins(0, 1, 10, 11, 1, 0); set_ins(1, 12, 1, 0, 1, 0); set_ins(2, 13, 14, 15, 1, 0);
    for (int m = 0; m < 4; m++) run_case(m, D1[m], st);

    // load used by the next instruction
    set_ins(0, 1, 10, 0, 1, 1); set_ins(1, 12, 0, 1, 1, 0); set_ins(2, 13, 14, 15, 1, 0);
    for (int m = 0; m < 4; m++) run_case(m, D2[m], st);

    // distance two only
    set_ins(0, 1, 10, 11, 1, 0); set_ins(1, 5, 6, 7, 1, 0); set_ins(2, 13, 1, 0, 1, 0);
    for (int m = 0; m < 4; m++) run_case(m, D3[m], st);

    // two sources, one at distance one, one at distance two
    set_ins(0, 1, 10, 11, 1, 0); set_ins(1, 2, 6, 7, 1, 0); set_ins(2, 13, 2, 1, 1, 0);
    for (int m = 0; m < 4; m++) run_case(m, D4[m], st);

    // same register written twice: younger wins (R4)
    set_ins(0, 1, 10, 11, 1, 0); set_ins(1, 1, 6, 7, 1, 0); set_ins(2, 13, 1, 0, 1, 0);
    run_case(3, 0, st);
    check(g_fa[2] == 2'b01, "R4", "select takes execute/memory result", g_fa[2], 1);

    // distance three reads the register file (R1)
    n_ins = 4;
    set_ins(0, 1, 10, 11, 1, 0); set_ins(1, 5, 6, 7, 1, 0); set_ins(2, 8, 9, 6, 1, 0); set_ins(3, 13, 1, 1, 1, 0);
    for (int m = 0; m < 4; m++) begin
      run_case(m, -1, st);
      check(st == 0 && g_fa[3] == 0 && g_fb[3] == 0, "R1", $sformatf("distance three mode %0d", m),
            st * 16 + {g_fa[3], g_fb[3]}, 0);
    end

    // register 0 and disabled writes are ignored (R7)
    n_ins = 3;
    set_ins(0, 0, 10, 11, 1, 1); set_ins(1, 3, 6, 7, 0, 1); set_ins(2, 13, 0, 3, 1, 0);
    for (int m = 0; m < 4; m++) begin
      run_case(m, 0, st);
      check(g_fa[2] == 0 && g_fb[2] == 0, "R7", $sformatf("no bypass from r0 or disabled write mode %0d", m),
            {g_fa[2], g_fb[2]}, 0);
    end

    // constrained random sequences
    void'($urandom(32'd20240611));
    n_ins = 6;
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < n_ins; i++)
        set_ins(i, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
                ($urandom % 4) != 0, ($urandom % 3) == 0);
      for (int m = 0; m < 4; m++) run_case(m, -1, st);
    end

    finish_report();
  end
endmodule